// File: doc/BRIEF.md
# Block Transfer Sequencer with Descending Source Walk

This block runs one memory-to-memory block copy over a 64-bit read bus and a 32-bit write bus. A start pulse captures the source address, the destination address, the byte count and two mode bits. The source side can walk upward or downward through memory. The destination side can advance by 4 bytes per store, or it can keep hitting one fixed 32-bit location, for example a device data port. The block raises done for one cycle once every byte has been stored.

When the source descends, the programmed source address points one byte past the last byte to move. Quadword loads then go from the highest one down to the lowest. The stored doublewords come out highest group first, but each doubleword keeps its bytes in ascending memory order. Loaded bytes pass through a small byte-granular staging buffer. Reads wait until a full quadword fits in that buffer. Writes wait until four bytes are present. Bytes of a boundary quadword that fall outside the transfer range are dropped on entry to the buffer.

Top module: `dma_xfer_seq`

## Requirements
- R1: A start_i pulse while busy_o is low captures all programmed values, and busy_o is high from the next cycle until the done cycle. A start_i pulse while busy_o is high is ignored. The two low bits of byte_cnt_i are ignored, so the transfer length is byte_cnt_i rounded down to a multiple of 4.
- R2: With src_dec_i=1, the byte range is [src_addr_i − len, src_addr_i). The first load goes to (src_addr_i − 1) rounded down to a multiple of 8. Each later load is 8 bytes lower. Exactly one load is issued per quadword the range touches.
- R3: With src_dec_i=0, the byte range is [src_addr_i, src_addr_i + len). The first load goes to src_addr_i rounded down to a multiple of 8. Each later load is 8 bytes higher. Exactly one load is issued per quadword the range touches.
- R4: Bytes of a loaded quadword that lie outside the byte range are never stored, and exactly len/4 stores are made.
- R5: In descending mode, store k (counting from 0) carries the four bytes starting at src_addr_i − 4(k+1). The lowest-addressed byte is in wr_data_o[7:0]. On rd_data_i, byte lane j holds the byte at rd_addr_o + j.
- R6: In ascending mode, store k carries the four bytes starting at src_addr_i + 4k. The lowest-addressed byte is in wr_data_o[7:0].
- R7: With dst_hold_i=1, every store goes to dst_addr_i with its low two bits cleared. With dst_hold_i=0, store k goes to that address plus 4k.
- R8: Every store drives wr_be_o = 4'hF.
- R9: done_o is high for exactly one cycle, right after the acknowledge of the last store, and busy_o is low in that cycle. A zero length gives a done_o pulse in the cycle after start with no bus traffic.
- R10: No load is issued while the staging buffer has room for fewer than 8 bytes. No store is issued while it holds fewer than 4 bytes.
- R11: Once rd_req_o or wr_req_o is raised, it stays high with its address and data unchanged until the matching acknowledge arrives. A request completes in a cycle where both the request and its ack are high, and rd_data_i is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| src_addr_i | input | AW | Source start address (one past the end when descending) |
| dst_addr_i | input | AW | Destination address |
| byte_cnt_i | input | CW | Transfer length in bytes |
| src_dec_i | input | 1 | 1: source descends, 0: source ascends |
| dst_hold_i | input | 1 | 1: fixed destination, 0: destination advances by 4 |
| rd_req_o | output | 1 | Quadword load request |
| rd_addr_o | output | AW | Load address, 8-byte aligned |
| rd_ack_i | input | 1 | Load acknowledge, data valid |
| rd_data_i | input | 64 | Load data |
| wr_req_o | output | 1 | Doubleword store request |
| wr_addr_o | output | AW | Store address, 4-byte aligned |
| wr_data_o | output | 32 | Store data |
| wr_be_o | output | 4 | Store byte enables |
| wr_ack_i | input | 1 | Store acknowledge |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with AW=32 and CW=16, and shrinks the staging buffer to BUF_BYTES=12. At that depth, a single aligned load leaves too little room for a second one. Holding back store acknowledges therefore shows the read stall directly. The 32-bit addresses let the descending case run at its natural high addresses, with unaligned ends, with a fixed destination and with a wrapped doubleword order. Random acknowledge gaps exercise the hold behaviour of both request channels.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam int QW_BYTES = 8;
  localparam int DW_BYTES = 4;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/dsq_src_rd.sv
module dsq_src_rd #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] src_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          dec_i,
  input  logic          room_i,
  input  logic          rd_ack_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_fire_o,
  output logic [2:0]    skip_o,
  output logic [3:0]    take_o,
  output logic          dec_o
);
  import dsq_pkg::*;

  logic [AW-1:0] addr_q;
  logic [CW-1:0] left_q;
  logic [2:0]    skip_q;
  logic          dec_q;
  logic [3:0]    avail;

  assign avail     = 4'(QW_BYTES) - {1'b0, skip_q};
  assign take_o    = (left_q < CW'(avail)) ? left_q[3:0] : avail;
  assign skip_o    = skip_q;
  assign dec_o     = dec_q;
  assign rd_addr_o = addr_q;
  assign rd_req_o  = (left_q != '0) && room_i;
  assign rd_fire_o = rd_req_o && rd_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      left_q <= '0;
      skip_q <= '0;
      dec_q  <= 1'b0;
    end else if (load_i) begin
      dec_q  <= dec_i;
      left_q <= cnt_i & ~CW'(3);
      // descending: bytes at or above src_i in the top quadword are dropped
      skip_q <= dec_i ? (3'd0 - src_i[2:0]) : src_i[2:0];
      addr_q <= dec_i ? ((src_i - AW'(1)) & ~AW'(7)) : (src_i & ~AW'(7));
    end else if (rd_fire_o) begin
      left_q <= left_q - CW'(take_o);
      skip_q <= '0;
      addr_q <= dec_q ? (addr_q - AW'(QW_BYTES)) : (addr_q + AW'(QW_BYTES));
    end
  end

  p_rd_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_addr_o[2:0] == 3'd0));

  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));
endmodule

// File: rtl/dsq_stage_buf.sv
module dsq_stage_buf #(
  parameter int BUF_BYTES = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        rd_fire_i,
  input  logic [63:0] rd_data_i,
  input  logic        rev_i,
  input  logic [2:0]  skip_i,
  input  logic [3:0]  take_i,
  input  logic        wr_fire_i,
  output logic        room_o,
  output logic        has_word_o,
  output logic [31:0] head_o
);
  import dsq_pkg::*;

  localparam int FW = $clog2(BUF_BYTES + 1);

  byte_t          mem_q [BUF_BYTES];
  byte_t          nxt   [BUF_BYTES];
  byte_t          sh    [BUF_BYTES];
  byte_t          lane  [QW_BYTES];
  logic [FW-1:0]  fill_q, base, fill_nxt;
  logic [2:0]     li;

  assign room_o     = fill_q <= FW'(BUF_BYTES - QW_BYTES);
  assign has_word_o = fill_q >= FW'(DW_BYTES);

  for (genvar g = 0; g < DW_BYTES; g++) begin : g_head
    assign head_o[8*g +: 8] = mem_q[g];
  end

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_shift
    if (g + DW_BYTES < BUF_BYTES) begin : g_mid
      assign sh[g] = wr_fire_i ? mem_q[g + DW_BYTES] : mem_q[g];
    end else begin : g_top
      assign sh[g] = wr_fire_i ? 8'h00 : mem_q[g];
    end
  end

  // stream order: descending mode puts the highest address in lane 0
  always_comb begin
    for (int j = 0; j < QW_BYTES; j++)
      lane[j] = rev_i ? rd_data_i[8*(QW_BYTES-1-j) +: 8] : rd_data_i[8*j +: 8];
  end

  assign base     = wr_fire_i ? (fill_q - FW'(DW_BYTES)) : fill_q;
  assign fill_nxt = base + (rd_fire_i ? FW'(take_i) : FW'(0));

  always_comb begin
    li = '0;
    for (int i = 0; i < BUF_BYTES; i++) begin
      nxt[i] = sh[i];
      li = 3'(i) - 3'(base) + skip_i;
      if (rd_fire_i && (i >= int'(base)) && (i < int'(base) + int'(take_i)))
        nxt[i] = lane[li];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      for (int i = 0; i < BUF_BYTES; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      fill_q <= '0;
    end else begin
      fill_q <= fill_nxt;
      for (int i = 0; i < BUF_BYTES; i++) mem_q[i] <= nxt[i];
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fire_i |-> (int'(fill_q) + QW_BYTES <= BUF_BYTES));

  p_wr_needs_word_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire_i |-> (int'(fill_q) >= DW_BYTES));
endmodule

// File: rtl/dsq_dst_wr.sv
module dsq_dst_wr #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          hold_i,
  input  logic          rev_i,
  input  logic          has_word_i,
  input  logic [31:0]   head_i,
  input  logic          wr_ack_i,
  output logic          load_o,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [31:0]   wr_data_o,
  output logic [3:0]    wr_be_o,
  output logic          wr_fire_o,
  output logic          busy_o,
  output logic          done_o
);
  logic          busy_q, done_q, hold_q;
  logic [CW-1:0] left_q, cnt4;
  logic [AW-1:0] addr_q;

  assign cnt4      = cnt_i & ~CW'(3);
  assign load_o    = start_i && !busy_q;
  assign wr_req_o  = busy_q && has_word_i;
  assign wr_fire_o = wr_req_o && wr_ack_i;
  assign wr_addr_o = addr_q;
  assign wr_be_o   = 4'hF;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  // head_i is in stream order; descending streams need the lanes swapped back
  assign wr_data_o = rev_i ? {head_i[7:0], head_i[15:8], head_i[23:16], head_i[31:24]}
                           : head_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      hold_q <= 1'b0;
      left_q <= '0;
      addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        left_q <= cnt4;
        hold_q <= hold_i;
        addr_q <= dst_i & ~AW'(3);
        if (cnt4 == '0) done_q <= 1'b1;
        else            busy_q <= 1'b1;
      end else if (wr_fire_o) begin
        left_q <= left_q - CW'(4);
        if (!hold_q) addr_q <= addr_q + AW'(4);
        if (left_q == CW'(4)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_wr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  p_dst_fixed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire_o && hold_q && busy_o) |=> $stable(wr_addr_o));
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int AW        = 32,
  parameter int CW        = 16,
  parameter int BUF_BYTES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [CW-1:0] byte_cnt_i,
  input  logic          src_dec_i,
  input  logic          dst_hold_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [63:0]   rd_data_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [31:0]   wr_data_o,
  output logic [3:0]    wr_be_o,
  input  logic          wr_ack_i,
  output logic          busy_o,
  output logic          done_o
);
  logic        load, room, has_word, rd_fire, wr_fire, dec;
  logic [2:0]  skip;
  logic [3:0]  take;
  logic [31:0] head;

  dsq_dst_wr #(.AW(AW), .CW(CW)) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .dst_i(dst_addr_i),
    .cnt_i(byte_cnt_i), .hold_i(dst_hold_i), .rev_i(dec), .has_word_i(has_word),
    .head_i(head), .wr_ack_i(wr_ack_i), .load_o(load), .wr_req_o(wr_req_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .wr_be_o(wr_be_o),
    .wr_fire_o(wr_fire), .busy_o(busy_o), .done_o(done_o)
  );

  dsq_src_rd #(.AW(AW), .CW(CW)) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .src_i(src_addr_i),
    .cnt_i(byte_cnt_i), .dec_i(src_dec_i), .room_i(room), .rd_ack_i(rd_ack_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_fire_o(rd_fire),
    .skip_o(skip), .take_o(take), .dec_o(dec)
  );

  dsq_stage_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load), .rd_fire_i(rd_fire),
    .rd_data_i(rd_data_i), .rev_i(dec), .skip_i(skip), .take_i(take),
    .wr_fire_i(wr_fire), .room_o(room), .has_word_o(has_word), .head_o(head)
  );

  p_start_ignored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> busy_o || done_o);
endmodule

// File: tb/dma_xfer_seq_tb_top.sv
module dma_xfer_seq_tb_top;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] src_addr_i = '0, dst_addr_i = '0;
  logic [CW-1:0] byte_cnt_i = '0;
  logic          src_dec_i = 1'b0, dst_hold_i = 1'b0;
  logic          rd_req_o, wr_req_o, busy_o, done_o;
  logic [AW-1:0] rd_addr_o, wr_addr_o;
  logic          rd_ack_i = 1'b0, wr_ack_i = 1'b0;
  logic [63:0]   rd_data_i = '0;
  logic [31:0]   wr_data_o;
  logic [3:0]    wr_be_o;

  always #4 clk_i = ~clk_i;

  dma_xfer_seq #(.AW(AW), .CW(CW), .BUF_BYTES(12)) dut_i (.*);

  int vec = 0, bad = 0;
  int rd_n = 0, wr_n = 0, done_n = 0, done_dbl = 0, hold_err = 0;
  logic          wr_block = 1'b0;
  logic [31:0]   rd_log [64];
  logic [31:0]   wa_log [64];
  logic [31:0]   wd_log [64];
  logic [3:0]    wb_log [64];

  function automatic logic [7:0] mb(input logic [31:0] a);
    return 8'(a * 13) ^ a[15:8];
  endfunction

  function automatic logic [63:0] qword(input logic [31:0] q);
    logic [63:0] d;
    for (int j = 0; j < 8; j++) d[8*j +: 8] = mb(q + 32'(j));
    return d;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bus responder: random ack gaps, logging and hold checks
  initial begin
    logic [15:0] lf = 16'hACE1;
    logic rp = 0, wp = 0, dp = 0;
    logic [31:0] ra = 0, wa = 0, wd = 0;
    forever begin
      @(negedge clk_i);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (rp && (!rd_req_o || rd_addr_o != ra)) hold_err++;
      if (wp && (!wr_req_o || wr_addr_o != wa || wr_data_o != wd)) hold_err++;
      if (rd_req_o && lf[0]) begin
        rd_ack_i  = 1'b1;
        rd_data_i = qword(rd_addr_o);
        if (rd_n < 64) rd_log[rd_n] = rd_addr_o;
        rd_n++;
      end else rd_ack_i = 1'b0;
      if (wr_req_o && !wr_block && lf[3]) begin
        wr_ack_i = 1'b1;
        if (wr_n < 64) begin
          wa_log[wr_n] = wr_addr_o; wd_log[wr_n] = wr_data_o; wb_log[wr_n] = wr_be_o;
        end
        wr_n++;
      end else wr_ack_i = 1'b0;
      rp = rd_req_o && !rd_ack_i; ra = rd_addr_o;
      wp = wr_req_o && !wr_ack_i; wa = wr_addr_o; wd = wr_data_o;
      if (done_o) begin
        done_n++;
        if (dp) done_dbl++;
      end
      dp = done_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  task automatic clear_logs();
    rd_n = 0; wr_n = 0; done_n = 0; done_dbl = 0;
  endtask

  task automatic launch(input logic [31:0] s, input logic [15:0] c, input logic d,
                        input logic [31:0] t, input logic h);
    @(negedge clk_i);
    clear_logs();
    src_addr_i = s; byte_cnt_i = c; src_dec_i = d; dst_addr_i = t; dst_hold_i = h;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    src_addr_i = 32'hDEAD_BEE0; dst_addr_i = 32'h1111_1110; byte_cnt_i = 16'h0040;
    src_dec_i = ~d; dst_hold_i = ~h;
    if ((c & 16'hFFFC) != 0) chk(busy_o == 1'b1, "R1 busy after start", 64'(busy_o), 1);
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_n == 0 && n < 4000) begin
      @(negedge clk_i);
      n++;
    end
    repeat (3) @(negedge clk_i);
    chk(done_n == 1, "R9 done pulse count", 64'(done_n), 1);
  endtask

  task automatic verify(input logic [31:0] s, input logic [15:0] c, input logic d,
                        input logic [31:0] t, input logic h);
    logic [31:0] c4 = {16'h0, c & 16'hFFFC};
    int nw = int'(c4 / 4);
    int nr = 0;
    logic [31:0] f = 0, l = 0, ea, sb;
    logic [31:0] ed;
    if (c4 != 0) begin
      f = d ? ((s - 1) & ~32'h7) : (s & ~32'h7);
      l = d ? ((s - c4) & ~32'h7) : ((s + c4 - 1) & ~32'h7);
      nr = int'((d ? (f - l) : (l - f)) / 8) + 1;
    end
    chk(done_dbl == 0, "R9 done one cycle", 64'(done_dbl), 0);
    chk(busy_o == 1'b0, "R9 busy low after done", 64'(busy_o), 0);
    chk(hold_err == 0, "R11 request hold", 64'(hold_err), 0);
    chk(rd_n == nr, d ? "R2 load count" : "R3 load count", 64'(rd_n), 64'(nr));
    for (int i = 0; i < nr && i < rd_n && i < 64; i++) begin
      ea = d ? f - 32'(8 * i) : f + 32'(8 * i);
      chk(rd_log[i] == ea, d ? "R2 load addr" : "R3 load addr", 64'(rd_log[i]), 64'(ea));
    end
    chk(wr_n == nw, "R4 store count", 64'(wr_n), 64'(nw));
    for (int k = 0; k < nw && k < wr_n && k < 64; k++) begin
      sb = d ? s - 32'(4 * (k + 1)) : s + 32'(4 * k);
      ed = {mb(sb + 3), mb(sb + 2), mb(sb + 1), mb(sb)};
      ea = (t & ~32'h3) + (h ? 32'h0 : 32'(4 * k));
      chk(wd_log[k] == ed, d ? "R5 store data" : "R6 store data", 64'(wd_log[k]), 64'(ed));
      chk(wa_log[k] == ea, "R7 store addr", 64'(wa_log[k]), 64'(ea));
      chk(wb_log[k] == 4'hF, "R8 byte enables", 64'(wb_log[k]), 64'hF);
    end
  endtask

  task automatic run(input logic [31:0] s, input logic [15:0] c, input logic d,
                     input logic [31:0] t, input logic h);
    launch(s, c, d, t, h);
    wait_done();
    verify(s, c, d, t, h);
  endtask

  task automatic t_reset();
    chk(busy_o == 0, "R1 reset busy", 64'(busy_o), 0);
    chk(done_o == 0, "R9 reset done", 64'(done_o), 0);
    chk(rd_req_o == 0, "R10 reset rd_req", 64'(rd_req_o), 0);
    chk(wr_req_o == 0, "R10 reset wr_req", 64'(wr_req_o), 0);
  endtask

  task automatic t_desc_fixed();   // R2 R5 R7: 20 bytes, 3 loads, 5 stores to one address
    run(32'hA000_0214, 16'h0014, 1'b1, 32'h4001_0304, 1'b1);
  endtask

  task automatic t_desc_unaligned(); // R4: both source ends inside a quadword
    run(32'h1000_0013, 16'h0010, 1'b1, 32'h2000_0041, 1'b0);
  endtask

  task automatic t_asc_unaligned(); // R3 R6
    run(32'h3000_0005, 16'h0018, 1'b0, 32'h5000_0008, 1'b0);
  endtask

  task automatic t_cnt_low_bits(); // R1: 14 bytes act as 12
    run(32'h3000_0100, 16'h000E, 1'b0, 32'h6000_000C, 1'b1);
  endtask

  task automatic t_zero();
    launch(32'h0000_0100, 16'h0003, 1'b1, 32'h0000_0200, 1'b0);
    repeat (4) @(negedge clk_i);
    chk(done_n == 1, "R9 zero length done", 64'(done_n), 1);
    chk(rd_n == 0 && wr_n == 0, "R9 zero length no traffic", 64'(rd_n + wr_n), 0);
    chk(busy_o == 0, "R9 zero length idle", 64'(busy_o), 0);
  endtask

  task automatic t_stall();        // R10
    wr_block = 1'b1;
    launch(32'h7000_0000, 16'h0020, 1'b0, 32'h7100_0000, 1'b0);
    repeat (40) @(negedge clk_i);
    chk(rd_n == 1, "R10 loads stall on full buffer", 64'(rd_n), 1);
    chk(wr_n == 0, "R10 no store while blocked", 64'(wr_n), 0);
    wr_block = 1'b0;
    wait_done();
    verify(32'h7000_0000, 16'h0020, 1'b0, 32'h7100_0000, 1'b0);
  endtask

  task automatic t_restart();      // R1: start while busy is ignored
    launch(32'h8000_0020, 16'h0018, 1'b1, 32'h8100_0010, 1'b1);
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1, "R1 busy mid transfer", 64'(busy_o), 1);
    src_addr_i = 32'h9000_0000; byte_cnt_i = 16'h0030; src_dec_i = 1'b0;
    dst_addr_i = 32'h9100_0000; dst_hold_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done();
    verify(32'h8000_0020, 16'h0018, 1'b1, 32'h8100_0010, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_desc_fixed();
    t_desc_unaligned();
    t_asc_unaligned();
    t_cnt_low_bits();
    t_zero();
    t_stall();
    t_restart();
    summary();
    $finish;
  end
endmodule